// File: doc/BRIEF.md
# FIFO Transit-Time Averager

This block measures how long a word spends inside a clock-domain-crossing FIFO. The FIFO's write side flips a marker line when it writes a tagged word. The read side flips its own marker line when that word leaves. Both lines are brought into a separate sampling clock, which is faster than either FIFO clock and independent of them. Each write-to-read gap is counted in sampling cycles. 256 such gaps are summed into one average with 8 fractional bits, so the 17-bit result is a mean in sampling cycles scaled by 256.

The result is handed to a consumer in another clock domain through a ready/acknowledge pair. When an average is loaded, ready goes high, and the value stays frozen until the consumer pulses acknowledge. The acknowledge pulse is turned into a toggle in the consumer's clock and synchronized into the sampling clock. Ready then drops and a fresh collection of 256 gaps starts from an empty sum.

The interval state machine has two states. IV_IDLE goes to IV_RUN on a write event, and IV_RUN goes back to IV_IDLE on a read event, which emits one sample. The handshake state machine also has two states. HS_COLLECT goes to HS_READY when the 256th sample is accepted, and HS_READY goes back to HS_COLLECT when an acknowledge is detected.

Top module: `transit_avg`

## Requirements
- R1: While reset is held and right after it is released, `avg_rdy` is 0 and `avg_val` is 0.
- R2: Suppose the write marker toggles just before sampling edge k and the read marker toggles just before edge k+d, with d at least 1. Then the sample recorded for that word is d.
- R3: `avg_val` is 17 bits: 9 integer bits and 8 fractional bits. It equals the plain sum of the 256 samples collected since the last restart, which is the mean multiplied by 256.
- R4: `avg_rdy` rises on the sampling edge that accepts the 256th sample, which is the third edge after the edge where that sample's read toggle is captured. It is still low one edge earlier. Once high, it stays high until an acknowledge is detected.
- R5: When the acknowledge clock is the sampling clock, `avg_rdy` is still high two edges after the acknowledge-clock edge that captures the `avg_ack` pulse. It is low after the third edge.
- R6: `avg_val` changes only when a new average is loaded. It holds its value while ready is high and after ready drops.
- R7: A sample that completes while ready is high is discarded. After an acknowledge, the sum and the sample count restart from zero.
- R8: A write event while an interval is running does not restart the interval or change its sample. A read event while no interval is running produces no sample.
- R9: An acknowledge detected while the block is still collecting samples is ignored.
- R10: When an acknowledge detection and a sample completion reach the handshake machine in the same cycle, ready drops and that sample is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_hr | input | 1 | Sampling clock, faster than both FIFO clocks |
| rst_hr | input | 1 | Synchronous active-high reset, sampling domain |
| wr_mark | input | 1 | Toggles when the tracked word is written (write domain) |
| rd_mark | input | 1 | Toggles when the tracked word is read (read domain) |
| ack_clk | input | 1 | Consumer clock |
| ack_rst | input | 1 | Synchronous active-high reset, consumer domain |
| avg_ack | input | 1 | One-cycle pulse from the consumer after it reads the value |
| avg_val | output | 17 | Averaged transit time, 8 fractional bits |
| avg_rdy | output | 1 | High while `avg_val` holds a new, unacknowledged average |

## Verification
Two events can reach the handshake machine in the same cycle: a detected acknowledge and a completed sample while ready is high. The bench lines them up by flipping the read marker and raising `avg_ack` on the same falling edge. Both paths then need three sampling edges to reach the machine. The outcome is judged two ways. Ready must fall on the expected edge. The following average must equal the sum of only the 256 samples driven after that point; a leaked sample shifts every later batch and changes the value.

// File: rtl/ta_pkg.sv
package ta_pkg;

    typedef enum logic {
        IV_IDLE = 1'b0,
        IV_RUN  = 1'b1
    } iv_state_t;

    typedef enum logic {
        HS_COLLECT = 1'b0,
        HS_READY   = 1'b1
    } hs_state_t;

endpackage

// File: rtl/ta_sync.sv
module ta_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] ev
);
    logic [W-1:0] stg [STAGES];
    logic [W-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= din;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= '0;
                else     stg[s] <= stg[s-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= stg[STAGES-1];
    end

    assign ev = stg[STAGES-1] ^ prev;
endmodule

// File: rtl/ta_ack_src.sv
module ta_ack_src (
    input  logic ack_clk,
    input  logic ack_rst,
    input  logic ack_pulse,
    output logic ack_tog
);
    always_ff @(posedge ack_clk) begin
        if (ack_rst)        ack_tog <= 1'b0;
        else if (ack_pulse) ack_tog <= ~ack_tog;
    end
endmodule

// File: rtl/ta_interval.sv
module ta_interval
    import ta_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_ev,
    input  logic             rd_ev,
    output logic             smp_vld,
    output logic [CNT_W-1:0] smp
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    iv_state_t        state, nxt;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) state <= IV_IDLE;
        else     state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            IV_IDLE: if (wr_ev) nxt = IV_RUN;
            IV_RUN:  if (rd_ev) nxt = IV_IDLE;
            default: nxt = IV_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            smp     <= '0;
            smp_vld <= 1'b0;
        end else begin
            smp_vld <= 1'b0;
            unique case (state)
                IV_IDLE: if (wr_ev) cnt <= CNT_W'(1);
                IV_RUN: begin
                    if (rd_ev) begin
                        smp_vld <= 1'b1;
                        smp     <= cnt;
                    end else if (cnt != CNT_MAX) begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                default: cnt <= '0;
            endcase
        end
    end

    assert_sample_nonzero_R2: assert property (@(posedge clk) disable iff (rst)
        smp_vld |-> (smp != '0));

    assert_sample_from_run_R8: assert property (@(posedge clk) disable iff (rst)
        smp_vld |-> ($past(state) == IV_RUN));
endmodule

// File: rtl/ta_accum.sv
module ta_accum
    import ta_pkg::*;
#(
    parameter int CNT_W      = 9,
    parameter int NSAMP_LOG2 = 8,
    parameter int FRAC_W     = 8,
    parameter int RES_W      = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_vld,
    input  logic [CNT_W-1:0] smp,
    input  logic             ack_ev,
    output logic [RES_W-1:0] avg_val,
    output logic             avg_rdy
);
    localparam int ACC_W = CNT_W + NSAMP_LOG2;
    localparam int SH    = NSAMP_LOG2 - FRAC_W;
    localparam logic [NSAMP_LOG2-1:0] LAST = '1;

    hs_state_t            state, nxt;
    logic [ACC_W-1:0]     acc;
    logic [ACC_W-1:0]     sum;
    logic [NSAMP_LOG2-1:0] n;
    logic                 last_smp;

    assign sum      = acc + ACC_W'(smp);
    assign last_smp = smp_vld && (n == LAST);

    always_ff @(posedge clk) begin
        if (rst) state <= HS_COLLECT;
        else     state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            HS_COLLECT: if (last_smp) nxt = HS_READY;
            HS_READY:   if (ack_ev)   nxt = HS_COLLECT;
            default:    nxt = HS_COLLECT;
        endcase
    end

    always_comb avg_rdy = (state == HS_READY);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc     <= '0;
            n       <= '0;
            avg_val <= '0;
        end else if (state == HS_COLLECT && smp_vld) begin
            if (n == LAST) begin
                avg_val <= RES_W'(sum >> SH);
                acc     <= '0;
                n       <= '0;
            end else begin
                acc <= sum;
                n   <= n + NSAMP_LOG2'(1);
            end
        end
    end

    assert_ready_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (avg_rdy && !ack_ev) |=> avg_rdy);

    assert_ready_rise_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(avg_rdy) |-> $past(smp_vld));

    assert_ready_drop_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(avg_rdy) |-> $past(ack_ev));

    assert_value_frozen_R6: assert property (@(posedge clk) disable iff (rst)
        (avg_rdy && $past(avg_rdy)) |-> $stable(avg_val));

    assert_sum_empty_R7: assert property (@(posedge clk) disable iff (rst)
        avg_rdy |-> (acc == '0 && n == '0));
endmodule

// File: rtl/transit_avg.sv
module transit_avg #(
    parameter int RES_W       = 17,
    parameter int FRAC_W      = 8,
    parameter int NSAMP_LOG2  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_hr,
    input  logic             rst_hr,
    input  logic             wr_mark,
    input  logic             rd_mark,
    input  logic             ack_clk,
    input  logic             ack_rst,
    input  logic             avg_ack,
    output logic [RES_W-1:0] avg_val,
    output logic             avg_rdy
);
    localparam int CNT_W = RES_W - FRAC_W;

    logic             ack_tog;
    logic [2:0]       ev;
    logic             smp_vld;
    logic [CNT_W-1:0] smp;

    ta_ack_src u_ack (
        .ack_clk  (ack_clk),
        .ack_rst  (ack_rst),
        .ack_pulse(avg_ack),
        .ack_tog  (ack_tog)
    );

    ta_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk_hr),
        .rst(rst_hr),
        .din({ack_tog, rd_mark, wr_mark}),
        .ev (ev)
    );

    ta_interval #(.CNT_W(CNT_W)) u_iv (
        .clk    (clk_hr),
        .rst    (rst_hr),
        .wr_ev  (ev[0]),
        .rd_ev  (ev[1]),
        .smp_vld(smp_vld),
        .smp    (smp)
    );

    ta_accum #(
        .CNT_W(CNT_W), .NSAMP_LOG2(NSAMP_LOG2),
        .FRAC_W(FRAC_W), .RES_W(RES_W)
    ) u_acc (
        .clk    (clk_hr),
        .rst    (rst_hr),
        .smp_vld(smp_vld),
        .smp    (smp),
        .ack_ev (ev[2]),
        .avg_val(avg_val),
        .avg_rdy(avg_rdy)
    );
endmodule

// File: tb/sim_transit_avg.sv
module sim_transit_avg;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_mark = 1'b0;
    logic        rd_mark = 1'b0;
    logic        avg_ack = 1'b0;
    logic [16:0] avg_val;
    logic        avg_rdy;

    int checks = 0;
    int errors = 0;
    int seen   = 0;
    bit done   = 1'b0;

    typedef struct { int val; string req; } exp_t;
    exp_t q[$];

    always #4 clk = ~clk;

    transit_avg u0 (
        .clk_hr(clk), .rst_hr(rst), .wr_mark(wr_mark), .rd_mark(rd_mark),
        .ack_clk(clk), .ack_rst(rst), .avg_ack(avg_ack),
        .avg_val(avg_val), .avg_rdy(avg_rdy)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // one tracked word: write toggle, read toggle d edges later, gap of 3
    task automatic one_sample(input int d, input bit extra_wr, input bit ack_at_rd);
        @(negedge clk) wr_mark = ~wr_mark;
        for (int i = 1; i < d; i++) begin
            @(negedge clk);
            if (extra_wr && i == 1) wr_mark = ~wr_mark;
        end
        @(negedge clk) begin rd_mark = ~rd_mark; avg_ack = ack_at_rd; end
        @(negedge clk) avg_ack = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic stray_rd();
        @(negedge clk) rd_mark = ~rd_mark;
        repeat (4) @(negedge clk);
    endtask

    task automatic loose_ack();
        @(negedge clk) avg_ack = 1'b1;
        @(negedge clk) avg_ack = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // acknowledge with exact drop timing
    task automatic timed_ack(input int held);
        @(negedge clk) avg_ack = 1'b1;
        @(negedge clk) avg_ack = 1'b0;
        @(negedge clk);
        @(negedge clk) chk(avg_rdy == 1'b1, "R5", "ready two edges after ack", avg_rdy, 1);
        @(negedge clk) chk(avg_rdy == 1'b0, "R5", "ready three edges after ack", avg_rdy, 0);
        chk(avg_val == held, "R6", "value after ready drop", avg_val, held);
    endtask

    // R4: ready low before the last sample is accepted, high right after
    task automatic finish_batch(input int d_last);
        one_sample(d_last, 1'b0, 1'b0);
        chk(avg_rdy == 1'b0, "R4", "ready before 256th accepted", avg_rdy, 0);
        @(negedge clk) chk(avg_rdy == 1'b1, "R4", "ready after 256th accepted", avg_rdy, 1);
    endtask

    // scoreboard monitor
    logic rdy_q = 1'b0;
    always @(negedge clk) begin
        if (!rst && avg_rdy && !rdy_q) begin
            if (q.size() == 0) begin
                chk(1'b0, "R3", "unexpected average", avg_val, -1);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(avg_val == e.val, e.req, "published average", avg_val, e.val);
                seen++;
            end
        end
        rdy_q = avg_rdy;
    end

    initial begin
        int sum_b, sum_c, held;
        repeat (3) @(negedge clk);
        chk(avg_rdy == 1'b0, "R1", "ready in reset", avg_rdy, 0);
        chk(avg_val == 0, "R1", "value in reset", avg_val, 0);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        chk(avg_rdy == 1'b0 && avg_val == 0, "R1", "after release", avg_val, 0);

        // batch A: constant gap 5 -> 5*256 (R2, R3)
        q.push_back('{5 * 256, "R2"});
        for (int i = 0; i < 255; i++) one_sample(5, 1'b0, 1'b0);
        finish_batch(5);
        repeat (20) @(negedge clk);
        chk(avg_rdy == 1'b1, "R4", "ready held without ack", avg_rdy, 1);
        chk(avg_val == 1280, "R6", "value held while ready", avg_val, 1280);
        timed_ack(1280);

        // batch B: varied gaps, stray reads, extra writes, early ack (R3, R8, R9)
        sum_b = 0;
        for (int i = 0; i < 256; i++) sum_b += 2 + ((i * 7) % 13);
        q.push_back('{sum_b, "R8"});
        for (int i = 0; i < 255; i++) begin
            if (i % 50 == 3) stray_rd();
            if (i == 100) loose_ack();
            one_sample(2 + ((i * 7) % 13), (i % 9 == 0), 1'b0);
        end
        chk(avg_rdy == 1'b0, "R9", "ack while collecting ignored", avg_rdy, 0);
        finish_batch(2 + ((255 * 7) % 13));
        held = sum_b;

        // samples while ready are discarded (R7); last one collides with ack (R10)
        for (int i = 0; i < 9; i++) one_sample(40, 1'b0, 1'b0);
        chk(avg_val == held, "R6", "value unchanged by discarded samples", avg_val, held);
        one_sample(40, 1'b0, 1'b1);
        chk(avg_rdy == 1'b1, "R10", "ready before collision edge", avg_rdy, 1);
        @(negedge clk) chk(avg_rdy == 1'b0, "R10", "ready after collision edge", avg_rdy, 0);
        chk(avg_val == held, "R6", "value after collision", avg_val, held);

        // batch C: must contain only the fresh samples (R7, R10)
        sum_c = 0;
        for (int i = 0; i < 256; i++) sum_c += 1 + (i % 9);
        q.push_back('{sum_c, "R7"});
        for (int i = 0; i < 255; i++) one_sample(1 + (i % 9), 1'b0, 1'b0);
        finish_batch(1 + (255 % 9));
        timed_ack(sum_c);

        repeat (10) @(negedge clk);
        chk(seen == 3, "R3", "averages published", seen, 3);
        chk(q.size() == 0, "R3", "pending expected averages", q.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "R4", "watchdog expired", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule